// File: doc/BRIEF.md
# Configuration Container Section Parser

This block reads a configuration container one byte at a time. It first checks a fixed 13-byte signature. It then walks a chain of tagged sections. Each section is a one-letter ASCII tag, a big-endian length, and that many content bytes.

Sections tagged 'a' through 'd' are informational. Their content is discarded. The section tagged 'e' carries the configuration bitstream. Its content passes straight through to a downstream byte stream, and its 32-bit length is published first. The parser stops on the first anomaly and raises an error flag. Otherwise it stops when the bitstream has been delivered or when the input ends.

The input is a valid/ready byte stream whose final byte carries an end-of-file flag. The output is a valid/ready byte stream with the bitstream bytes, a length value with its own valid flag, and three sticky status flags: done, found and error. One parse runs per reset.

Top module: `cfg_section_parser`

## Requirements
- R1: After reset, done_o, found_o, error_o, pay_len_valid_o and out_valid_o are 0, and in_ready_o is 1.
- R2: The first 13 bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. Any byte that differs sets error_o and done_o, with found_o 0. An end-of-file flag on any of these bytes except the 13th also sets error_o and done_o.
- R3: A tag byte below 0x61 ('a') or above 0x65 ('e') sets error_o and done_o, with found_o 0.
- R4: Tags 0x61 to 0x64 take a 2-byte big-endian length. Exactly that many content bytes are consumed without appearing on the output, and the next byte is read as a tag. A length of 0 is allowed.
- R5: A tag 0x61 to 0x64 whose length exceeds 255 sets error_o and done_o.
- R6: Tag 0x65 takes a 4-byte big-endian length, which may exceed 255. One cycle after its last length byte is accepted, pay_len_o holds that length, and pay_len_valid_o and found_o are 1. Both hold before any payload byte is offered and stay stable afterwards.
- R7: The content of section 0x65 appears on out_data_o in arrival order, exactly pay_len_o bytes. After the last byte, done_o is 1 and error_o is 0.
- R8: While a payload byte is offered and out_ready_i is 0, in_ready_o is 0 and no input is consumed.
- R9: An end-of-file flag at or after a section tag, and before section 0x65 has been reached, sets done_o with found_o and error_o both 0.
- R10: An end-of-file flag on a payload byte that is not the last one sets done_o and error_o, with found_o 1.
- R11: A 0x65 section of length 0 sets done_o and found_o with no output byte.
- R12: Once done_o is 1, in_ready_o and out_valid_o stay 0, and done_o, found_o and error_o keep their values until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte valid |
| in_last_i | input | 1 | End of file, marks the final input byte |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| out_data_o | output | 8 | Bitstream byte |
| out_valid_o | output | 1 | Bitstream byte valid |
| out_ready_i | input | 1 | Downstream can take a byte |
| pay_len_o | output | 32 | Length of the bitstream section |
| pay_len_valid_o | output | 1 | pay_len_o is meaningful |
| found_o | output | 1 | Bitstream section reached |
| error_o | output | 1 | Parse aborted on a bad signature, tag, length or truncation |
| done_o | output | 1 | Parse finished |

## Verification
The end-of-file flag and the payload byte count can resolve on the same accepted byte. The bench places the flag exactly on the final payload byte and expects done with no error. It then places the flag three bytes early and expects done with error and exactly three delivered bytes. The same overlap arises when the flag rides on the last length byte of a zero-length bitstream section, where found must win over the end-of-file path. Backpressure toggled during delivery checks that stalls never drop or repeat a byte across these boundaries.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int PRE_LEN = 13;

  typedef enum logic [2:0] {
    ST_PRE,
    ST_TAG,
    ST_LEN,
    ST_SKIP,
    ST_PAY,
    ST_FIN
  } csp_state_e;

  localparam logic [7:0] TAG_MIN = 8'h61;
  localparam logic [7:0] TAG_MAX = 8'h65;
  localparam logic [7:0] TAG_BITS = 8'h65;

  function automatic logic [7:0] sig_byte(input int idx);
    case (idx)
      0, 10, 11:   sig_byte = 8'h00;
      1:           sig_byte = 8'h09;
      2, 4, 6, 8:  sig_byte = 8'h0F;
      3, 5, 7, 9:  sig_byte = 8'hF0;
      12:          sig_byte = 8'h01;
      default:     sig_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/csp_sig_match.sv
module csp_sig_match #(
  parameter int SIG_LEN = 13,
  localparam int IW = $clog2(SIG_LEN + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic       last_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign hit_o  = (byte_i == csp_pkg::sig_byte(int'(idx_q)));
  assign last_o = (int'(idx_q) == SIG_LEN - 1);
endmodule

// File: rtl/csp_len_acc.sv
module csp_len_acc #(
  parameter int LEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic [7:0]       byte_i,
  output logic [LEN_W-1:0] next_o
);
  logic [LEN_W-1:0] acc_q;

  // value including the byte being accepted this cycle
  assign next_o = {acc_q[LEN_W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (shift_i)  acc_q <= next_o;
  end
endmodule

// File: rtl/csp_down_cnt.sv
module csp_down_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         one_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign one_o = (cnt_q == W'(1));
endmodule

// File: rtl/cfg_section_parser.sv
module cfg_section_parser #(
  parameter int LEN_W     = 32,
  parameter int SHORT_MAX = 255,
  parameter int LONG_HDR  = 4,
  parameter int SHORT_HDR = 2,
  localparam int HW = $clog2(LONG_HDR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       in_data_i,
  input  logic             in_valid_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  output logic [7:0]       out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [LEN_W-1:0] pay_len_o,
  output logic             pay_len_valid_o,
  output logic             found_o,
  output logic             error_o,
  output logic             done_o
);
  import csp_pkg::*;

  csp_state_e st_q, st_d;
  logic       take;
  logic       sig_hit, sig_last, sig_step;
  logic       len_clr, len_shift;
  logic [LEN_W-1:0] len_next;
  logic       cnt_load, cnt_dec, cnt_one;
  logic [HW-1:0] hdr_q, hdr_d;
  logic       is_bits_q, is_bits_d;
  logic       set_done, set_err, set_found, cap_len;
  logic       tag_bad;

  assign in_ready_o  = (st_q == ST_PAY) ? out_ready_i : (st_q != ST_FIN);
  assign out_valid_o = (st_q == ST_PAY) && in_valid_i;
  assign out_data_o  = in_data_i;
  assign take        = in_valid_i && in_ready_o;
  assign tag_bad     = (in_data_i < TAG_MIN) || (in_data_i > TAG_MAX);

  csp_sig_match #(.SIG_LEN(PRE_LEN)) u_sig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (sig_step),
    .byte_i (in_data_i),
    .hit_o  (sig_hit),
    .last_o (sig_last)
  );

  csp_len_acc #(.LEN_W(LEN_W)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (len_clr),
    .shift_i (len_shift),
    .byte_i  (in_data_i),
    .next_o  (len_next)
  );

  csp_down_cnt #(.W(LEN_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (len_next),
    .dec_i  (cnt_dec),
    .one_o  (cnt_one)
  );

  always_comb begin
    st_d      = st_q;
    hdr_d     = hdr_q;
    is_bits_d = is_bits_q;
    sig_step  = 1'b0;
    len_clr   = 1'b0;
    len_shift = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    set_done  = 1'b0;
    set_err   = 1'b0;
    set_found = 1'b0;
    cap_len   = 1'b0;
    if (take) begin
      unique case (st_q)
        ST_PRE: begin
          sig_step = 1'b1;
          if (!sig_hit) begin
            set_err = 1'b1; set_done = 1'b1;
          end else if (sig_last) begin
            st_d = ST_TAG;
            if (in_last_i) set_done = 1'b1;
          end else if (in_last_i) begin
            set_err = 1'b1; set_done = 1'b1;
          end
        end
        ST_TAG: begin
          if (tag_bad) begin
            set_err = 1'b1; set_done = 1'b1;
          end else begin
            len_clr   = 1'b1;
            is_bits_d = (in_data_i == TAG_BITS);
            hdr_d     = (in_data_i == TAG_BITS) ? HW'(LONG_HDR - 1) : HW'(SHORT_HDR - 1);
            st_d      = ST_LEN;
            if (in_last_i) set_done = 1'b1;
          end
        end
        ST_LEN: begin
          len_shift = 1'b1;
          if (hdr_q != '0) begin
            hdr_d = hdr_q - 1'b1;
            if (in_last_i) set_done = 1'b1;
          end else if (is_bits_q) begin
            set_found = 1'b1;
            cap_len   = 1'b1;
            cnt_load  = 1'b1;
            st_d      = ST_PAY;
            if (len_next == '0) begin
              set_done = 1'b1;
            end else if (in_last_i) begin
              set_done = 1'b1; set_err = 1'b1;
            end
          end else if (len_next > LEN_W'(SHORT_MAX)) begin
            set_err = 1'b1; set_done = 1'b1;
          end else begin
            cnt_load = 1'b1;
            st_d     = (len_next == '0) ? ST_TAG : ST_SKIP;
            if (in_last_i) set_done = 1'b1;
          end
        end
        ST_SKIP: begin
          cnt_dec = 1'b1;
          if (cnt_one) st_d = ST_TAG;
          if (in_last_i) set_done = 1'b1;
        end
        ST_PAY: begin
          cnt_dec = 1'b1;
          if (cnt_one) begin
            set_done = 1'b1;
          end else if (in_last_i) begin
            set_done = 1'b1; set_err = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (set_done) st_d = ST_FIN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q            <= ST_PRE;
      hdr_q           <= '0;
      is_bits_q       <= 1'b0;
      pay_len_o       <= '0;
      pay_len_valid_o <= 1'b0;
      found_o         <= 1'b0;
      error_o         <= 1'b0;
      done_o          <= 1'b0;
    end else begin
      st_q      <= st_d;
      hdr_q     <= hdr_d;
      is_bits_q <= is_bits_d;
      if (cap_len) begin
        pay_len_o       <= len_next;
        pay_len_valid_o <= 1'b1;
      end
      if (set_found) found_o <= 1'b1;
      if (set_err)   error_o <= 1'b1;
      if (set_done)  done_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_section_parser_chk.sv
module cfg_section_parser_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [LEN_W-1:0] pay_len_o,
  input logic             pay_len_valid_o,
  input logic             found_o,
  input logic             error_o,
  input logic             done_o
);
  logic [LEN_W-1:0] n_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         n_out <= '0;
    else if (out_valid_o && out_ready_i) n_out <= n_out + 1'b1;
  end

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!in_ready_o && !out_valid_o)); // R12
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(found_o) && $stable(error_o))); // R12
  AST_LEN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (pay_len_valid_o && found_o)); // R6
  AST_LEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_len_valid_o |=> (pay_len_valid_o && $stable(pay_len_o))); // R6
  AST_OUT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (n_out < pay_len_o)); // R7
  AST_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o); // R8
  AST_ERR_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o); // R2
endmodule

bind cfg_section_parser cfg_section_parser_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_ready_o      (in_ready_o),
  .in_valid_i      (in_valid_i),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .pay_len_o       (pay_len_o),
  .pay_len_valid_o (pay_len_valid_o),
  .found_o         (found_o),
  .error_o         (error_o),
  .done_o          (done_o)
);

// File: tb/tb_cfg_section_parser.sv
module tb_cfg_section_parser;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_last_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  out_data_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] pay_len_o;
  logic        pay_len_valid_o;
  logic        found_o, error_o, done_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  cfg_section_parser dut (
    .clk_i, .rst_ni, .in_data_i, .in_valid_i, .in_last_i, .in_ready_o,
    .out_data_o, .out_valid_o, .out_ready_i, .pay_len_o, .pay_len_valid_o,
    .found_o, .error_o, .done_o
  );

  typedef struct packed {
    int   bad_sig;   // index of corrupted signature byte, -1 none
    int   sk_tag;    // tag of the skipped section, -1 none
    int   sk_len;
    int   e_len;     // -1 no bitstream section
    int   eof_after; // payload bytes sent before end of file, -1 all
    logic stall;
    logic ex_found;
    logic ex_err;
    int   ex_out;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{-1, 97,   3,   5, -1, 1'b0, 1'b1, 1'b0,   5},  // R4 R7
    '{ 4, -1,   0,   5, -1, 1'b0, 1'b0, 1'b1,   0},  // R2
    '{12, -1,   0,   5, -1, 1'b0, 1'b0, 1'b1,   0},  // R2
    '{-1, 99, 255,   2, -1, 1'b0, 1'b1, 1'b0,   2},  // R4 limit
    '{-1, 98, 256,   2, -1, 1'b0, 1'b0, 1'b1,   0},  // R5
    '{-1,102,   2,   3, -1, 1'b0, 1'b0, 1'b1,   0},  // R3 above
    '{-1,100,   2,  -1, -1, 1'b0, 1'b0, 1'b0,   0},  // R9
    '{-1, -1,   0,   0, -1, 1'b0, 1'b1, 1'b0,   0},  // R11
    '{-1, 97,   1,   6,  3, 1'b0, 1'b1, 1'b1,   3},  // R10
    '{-1, 98,   0,   4, -1, 1'b1, 1'b1, 1'b0,   4},  // R8 R4 zero
    '{-1, 96,   2,   3, -1, 1'b0, 1'b0, 1'b1,   0},  // R3 below
    '{-1, -1,   0, 300, -1, 1'b1, 1'b1, 1'b0, 300}   // R6 long
  };

  logic [7:0] strm [0:1023];
  int slen;

  function automatic logic [7:0] sig_b(input int i);
    case (i)
      0, 10, 11:  return 8'h00;
      1:          return 8'h09;
      2, 4, 6, 8: return 8'h0F;
      3, 5, 7, 9: return 8'hF0;
      default:    return 8'h01;
    endcase
  endfunction

  function automatic logic [7:0] pay_b(input int i);
    return 8'((i * 7) + 3);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid_i = 1'b0;
    in_last_i = 1'b0;
    out_ready_i = 1'b1;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic build(input vec_t v);
    slen = 0;
    for (int i = 0; i < 13; i++) begin strm[slen] = sig_b(i); slen++; end
    if (v.bad_sig >= 0) strm[v.bad_sig] = strm[v.bad_sig] ^ 8'h40;
    if (v.sk_tag >= 0) begin
      strm[slen] = 8'(v.sk_tag); slen++;
      strm[slen] = 8'(v.sk_len >> 8); slen++;
      strm[slen] = 8'(v.sk_len); slen++;
      for (int i = 0; i < v.sk_len; i++) begin strm[slen] = 8'hA5 ^ 8'(i); slen++; end
    end
    if (v.e_len >= 0) begin
      strm[slen] = 8'h65; slen++;
      for (int k = 3; k >= 0; k--) begin strm[slen] = 8'(v.e_len >> (8 * k)); slen++; end
      for (int i = 0; i < ((v.eof_after >= 0) ? v.eof_after : v.e_len); i++) begin
        strm[slen] = pay_b(i); slen++;
      end
    end
  endtask

  task automatic run_vec(input int n);
    vec_t v;
    int idx, n_out, data_bad;
    logic took, done_seen, stall_bad, len_bad, stalled;
    v = VECS[n];
    build(v);
    do_reset();
    idx = 0; n_out = 0; data_bad = 0;
    done_seen = 1'b0; stall_bad = 1'b0; len_bad = 1'b0; stalled = 1'b0;
    for (int cyc = 0; cyc < 4000 && !done_seen; cyc++) begin
      @(negedge clk_i);
      out_ready_i = v.stall ? ((cyc % 3) != 0) : 1'b1;
      if (idx < slen) begin
        in_valid_i = 1'b1;
        in_data_i = strm[idx];
        in_last_i = (idx == slen - 1);
      end else begin
        in_valid_i = 1'b0;
        in_last_i = 1'b0;
      end
      #2;
      if (out_valid_o && !out_ready_i) begin
        stalled = 1'b1;
        if (in_ready_o) stall_bad = 1'b1;
      end
      if (out_valid_o && out_ready_i) begin
        if (n_out == 0 && !(pay_len_valid_o && pay_len_o == 32'(v.e_len))) len_bad = 1'b1;
        if (out_data_o != pay_b(n_out)) data_bad++;
        n_out++;
      end
      took = in_valid_i && in_ready_o;
      @(posedge clk_i);
      if (took) idx++;
      #1;
      if (done_o) done_seen = 1'b1;
    end
    @(negedge clk_i);
    in_valid_i = 1'b1;
    in_last_i = 1'b0;
    #2;
    check(done_o == 1'b1, "R12 done", int'(done_o), 1);
    check(in_ready_o == 1'b0 && out_valid_o == 1'b0, "R12 quiet after done",
          int'(in_ready_o), 0);
    check(found_o == v.ex_found, "R6 R9 found", int'(found_o), int'(v.ex_found));
    check(error_o == v.ex_err, "R2 R3 R5 R10 error", int'(error_o), int'(v.ex_err));
    check(n_out == v.ex_out, "R4 R7 R11 byte count", n_out, v.ex_out);
    if (v.ex_out > 0) begin
      check(data_bad == 0, "R7 byte order", data_bad, 0);
      check(!len_bad, "R6 length before first byte", int'(pay_len_o), v.e_len);
    end
    if (v.ex_found) check(pay_len_o == 32'(v.e_len), "R6 length value", int'(pay_len_o), v.e_len);
    if (v.stall) check(stalled && !stall_bad, "R8 backpressure", int'(stall_bad), 0);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #2;
    // R1 reset state
    check(!done_o && !found_o && !error_o && !pay_len_valid_o, "R1 status", int'(done_o), 0);
    check(in_ready_o == 1'b1 && out_valid_o == 1'b0, "R1 handshake", int'(in_ready_o), 1);
    for (int n = 0; n < NV; n++) run_vec(n);
    // R2 directed: end of file inside the signature
    do_reset();
    @(negedge clk_i);
    in_valid_i = 1'b1; in_data_i = 8'h00; in_last_i = 1'b0;
    @(negedge clk_i);
    in_data_i = 8'h09; in_last_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0; in_last_i = 1'b0;
    #2;
    check(done_o && error_o && !found_o, "R2 short signature", int'(error_o), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule